// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the two least significant word address bits for a four-beat burst in a synchronous memory. A new access captures the two external low address bits as the burst start. Each following advance moves to the next beat. The order of the beats is either linear, where the beat number is added to the start modulo four, or interleaved, where the beat number is XORed into the start.

A single step control chooses between starting a new burst and advancing the current one. An active-low clock enable freezes every register and makes the block ignore all of its other inputs. The order select is sampled on enabled clock edges together with the other inputs. The block drives the current low address bits and the captured start value. The upper address bits, the array and the data path are handled elsewhere.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, and after it is released until the first enabled edge, offs_o and start_o are both 0.
- R2: On a rising edge with clk_en_ni=0 and step_i=0, start_o takes low_addr_i, the beat count returns to 0, and offs_o equals low_addr_i from that edge on.
- R3: On a rising edge with clk_en_ni=0 and step_i=1, the beat count goes up by one modulo 4 and start_o keeps its value.
- R4: With ilv_i=0 sampled at the last enabled edge, offs_o = (start_o + beat) mod 4, so start 2 gives 2,3,0,1.
- R5: With ilv_i=1 sampled at the last enabled edge, offs_o = start_o XOR beat, so start 1 gives 1,0,3,2 and start 3 gives 3,2,1,0.
- R6: The step after the fourth beat returns offs_o to the start value, and the sequence repeats.
- R7: On a rising edge with clk_en_ni=1, step_i, ilv_i and low_addr_i are ignored, and offs_o and start_o keep their values.
- R8: ilv_i is registered on every enabled edge. A change of ilv_i in the middle of a burst alters the order from the next enabled edge on and does not reset the beat count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low. When high, all state is held |
| step_i | input | 1 | 0 starts a new burst, 1 advances to the next beat |
| ilv_i | input | 1 | Order select: 1 interleaved, 0 linear |
| low_addr_i | input | 2 | External low address bits, used as the start value |
| offs_o | output | 2 | Current low address bits of the burst |
| start_o | output | 2 | Start value captured for the current burst |

## Verification
The bench runs bursts in both orders and from several start values. It checks that the fifth step wraps back to the start value. A counter that saturated at beat 3 would hold the last address, and one that restarted at 0 would give a wrong value for any start other than 0. It holds the clock enable inactive while applying a load, an advance and a change of order, and then checks the outputs. A block that leaked any of these through would show a new start or a moved offset. It also switches the order in the middle of a burst, where a design that reset the beat count or ignored the new mode would give a wrong address. Asserting reset in the middle of a burst must bring both outputs back to zero.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  function automatic beat_t beat_addr(input beat_t start, input beat_t beat, input logic ilv);
    beat_addr = ilv ? (start ^ beat) : beat_t'(start + beat);
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  step_i,
  input  logic  ilv_i,
  input  beat_t low_addr_i,
  output beat_t start_o,
  output beat_t beat_o,
  output logic  ilv_o
);
  beat_t start_q, beat_q;
  logic  ilv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      beat_q  <= '0;
      ilv_q   <= 1'b0;
    end else if (en_i) begin
      ilv_q <= ilv_i;
      if (!step_i) begin
        start_q <= low_addr_i;
        beat_q  <= '0;
      end else begin
        beat_q <= beat_q + 1'b1; // wraps after the fourth beat
      end
    end
  end

  assign start_o = start_q;
  assign beat_o  = beat_q;
  assign ilv_o   = ilv_q;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !step_i) |=> (start_q == $past(low_addr_i) && beat_q == '0));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i) |=> (beat_q == beat_t'($past(beat_q) + 1'b1) && $stable(start_q)));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(start_q) && $stable(beat_q) && $stable(ilv_q)));
  p_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (ilv_q == $past(ilv_i)));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  beat_t start_i,
  input  beat_t beat_i,
  input  logic  ilv_i,
  output beat_t addr_o
);
  always_comb addr_o = beat_addr(start_i, beat_i, ilv_i);

  always_comb begin
    if (beat_i == '0) p_first_beat_r6: assert (addr_o == start_i);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clk_en_ni,
  input  logic       step_i,
  input  logic       ilv_i,
  input  logic [1:0] low_addr_i,
  output logic [1:0] offs_o,
  output logic [1:0] start_o
);
  beat_t start_w, beat_w;
  logic  ilv_w;

  burst_beat_ctr u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (!clk_en_ni),
    .step_i     (step_i),
    .ilv_i      (ilv_i),
    .low_addr_i (low_addr_i),
    .start_o    (start_w),
    .beat_o     (beat_w),
    .ilv_o      (ilv_w)
  );

  burst_order_map u_map (
    .start_i (start_w),
    .beat_i  (beat_w),
    .ilv_i   (ilv_w),
    .addr_o  (offs_o)
  );

  assign start_o = start_w;

  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> ($stable(offs_o) && $stable(start_o)));
  p_out_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !step_i) |=> (offs_o == $past(low_addr_i)));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b1, step = 1'b0, ilv = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [1:0] offs, start;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_ni(en_n), .step_i(step),
    .ilv_i(ilv), .low_addr_i(addr), .offs_o(offs), .start_o(start)
  );

  // {en_n, step, ilv, addr[1:0], exp_offs[1:0], exp_start[1:0], req[3:0]}
  localparam int NV = 21;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,2'd2, 2'd2,2'd2, 4'd2}, // R2 load 2
    {1'b0,1'b1,1'b0,2'd0, 2'd3,2'd2, 4'd4}, // R4 linear
    {1'b0,1'b1,1'b0,2'd0, 2'd0,2'd2, 4'd4},
    {1'b0,1'b1,1'b0,2'd0, 2'd1,2'd2, 4'd3}, // R3 start kept
    {1'b0,1'b1,1'b0,2'd3, 2'd2,2'd2, 4'd6}, // R6 wrap
    {1'b0,1'b0,1'b1,2'd1, 2'd1,2'd1, 4'd2}, // load 1
    {1'b0,1'b1,1'b1,2'd0, 2'd0,2'd1, 4'd5}, // R5 interleaved
    {1'b0,1'b1,1'b1,2'd0, 2'd3,2'd1, 4'd5},
    {1'b0,1'b1,1'b1,2'd0, 2'd2,2'd1, 4'd5},
    {1'b0,1'b1,1'b1,2'd0, 2'd1,2'd1, 4'd6}, // wrap
    {1'b1,1'b0,1'b0,2'd3, 2'd1,2'd1, 4'd7}, // R7 load+mode ignored
    {1'b1,1'b1,1'b0,2'd2, 2'd1,2'd1, 4'd7}, // advance ignored
    {1'b0,1'b0,1'b0,2'd3, 2'd3,2'd3, 4'd2}, // load 3
    {1'b0,1'b1,1'b0,2'd0, 2'd0,2'd3, 4'd4},
    {1'b0,1'b1,1'b1,2'd0, 2'd1,2'd3, 4'd8}, // R8 switch mid-burst
    {1'b0,1'b1,1'b1,2'd0, 2'd0,2'd3, 4'd8},
    {1'b0,1'b0,1'b1,2'd0, 2'd0,2'd0, 4'd2}, // load 0
    {1'b0,1'b1,1'b1,2'd0, 2'd1,2'd0, 4'd5},
    {1'b0,1'b1,1'b1,2'd0, 2'd2,2'd0, 4'd5},
    {1'b0,1'b1,1'b1,2'd0, 2'd3,2'd0, 4'd5},
    {1'b0,1'b1,1'b1,2'd0, 2'd0,2'd0, 4'd6}
  };

  task automatic check(input string req, input logic [1:0] eo, input logic [1:0] es);
    checks++;
    if (offs !== eo || start !== es) begin
      errors++;
      $display("FAIL %s: offs=%0d start=%0d expected offs=%0d start=%0d", req, offs, start, eo, es);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 2'd0, 2'd0);
        rst_n = 1'b1;
        en_n = 1'b1; step = 1'b0; addr = 2'd3;
        @(negedge clk);
        check("R1 after release, held", 2'd0, 2'd0);
        for (int i = 0; i < NV; i++) begin
          {en_n, step, ilv, addr} = VEC[i][12:8];
          @(negedge clk);
          check($sformatf("R%0d vec %0d", VEC[i][3:0], i), VEC[i][7:6], VEC[i][5:4]);
        end
        // R1: reset mid-burst
        en_n = 1'b0; step = 1'b0; addr = 2'd2; ilv = 1'b0;
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1 async clear", 2'd0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: long hold with toggling inputs
        en_n = 1'b0; step = 1'b0; addr = 2'd1; ilv = 1'b1;
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        en_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
          step = k[0]; addr = 2'(k); ilv = ~k[0];
          @(negedge clk);
          check("R7 hold", 2'd0, 2'd1);
        end
        done = 1'b1;
      end
      begin
        repeat (2000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual=timeout expected=done");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule